// File: doc/BRIEF.md
# Two-Mode Bus Grant Arbiter

The arbiter hands ownership of a shared PCI bus to one of five masters: the host bridge, which holds the arbiter, and four external devices, each with its own request and grant pair. A single mode input picks the scheme. In fixed mode the host wins ahead of every other requester, and the devices follow in index order. In rotating mode an ordered priority list is kept. The master that wins a decision moves to the end of that list, and the other entries keep their relative order.

A grant moves only when the bus is idle or the present owner has let go of its request. When nobody is requesting, the bus parks on the host. Exactly one grant line is high at all times, so the bus always has an owner. The priority list survives a change of mode. A new mode setting is applied at the next decision.

Top module: `pci_bus_arbiter`

## Requirements
- R1: Exactly one bit of `gnt_o` is 1 in every cycle. Bit 0 is the host bridge and bits 1 to 4 are devices 0 to 3. The same bit mapping applies to `req_i`.
- R2: While reset is active, and in the first cycle after it, `gnt_o` is 5'b00001 (host).
- R3: A decision happens at a clock edge where `bus_idle_i`=1 or the current owner's request bit is 0, and at least one request is set. In a decision with `mode_rr_i`=0, the new grant is the lowest-numbered requesting bit.
- R4: In a decision with `mode_rr_i`=0 and `req_i[0]`=1, the host is granted whatever else is requesting.
- R5: In a decision with `mode_rr_i`=1, the grant goes to the requester that stands earliest in the stored list. That master is then moved to the tail of the list, and the other entries keep their relative order.
- R6: After reset, the stored list is host, device 0, device 1, device 2, device 3.
- R7: The grant does not change at an edge where `bus_idle_i`=0 and the current owner still requests.
- R8: At an edge where a change is allowed and no request is set, `gnt_o` becomes 5'b00001 (parked on host).
- R9: Fixed-mode decisions leave the stored list unchanged. Switching `mode_rr_i` does not reset the list, and the new mode applies from the next decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 5 | Request lines; bit 0 host, bits 1..4 devices 0..3 |
| mode_rr_i | input | 1 | 0 = fixed priority, 1 = rotating priority |
| bus_idle_i | input | 1 | 1 when the bus has no transaction in progress |
| gnt_o | output | 5 | One-hot grant lines, same bit mapping as `req_i` |

## Verification
Two things can happen at the same edge: a grant hand-over and the rotation of the priority list. The grant has to come from the list as it stood before that edge, and only the winner may move to the tail. A bench model is checked against the design on every cycle while random requests, mode flips and idle indications fire decisions back to back. Directed sequences switch mode in the middle of a rotation to show the list is kept. Other cases hold the bus busy while higher-priority masters request, to show the owner keeps its grant.

// File: rtl/pci_arb_pkg.sv
// Shared constants for the bus arbiter.
// Assumes index 0 is always the host bridge.
package pci_arb_pkg;
    localparam int unsigned NUM_M  = 5;
    localparam int unsigned IDX_W  = $clog2(NUM_M);
    localparam int unsigned HOST   = 0;
endpackage

// File: rtl/arb_prio_list.sv
// Ordered priority list for rotating arbitration.
// Holds a permutation of master indices, where entry 0 has the highest priority.
// On upd_i the entry equal to win_i is taken out and appended at the tail.
// Assumes win_i is always present in the list.
module arb_prio_list #(
    parameter int unsigned N_M   = pci_arb_pkg::NUM_M,
    localparam int unsigned IW   = $clog2(N_M)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_i,
    input  logic [IW-1:0]     win_i,
    output logic [N_M*IW-1:0] order_o
);
    logic [IW-1:0] order_q [N_M];
    logic [IW-1:0] order_d [N_M];
    logic [IW-1:0] pos;
    logic [(1<<IW)-1:0] seen;

    // Locate the position of the winning index in the list.
    always_comb begin
        pos = '0;
        for (int k = 0; k < N_M; k++)
            if (order_q[k] == win_i) pos = IW'(k);
    end

    // Shift entries behind the winner forward and put the winner at the tail.
    always_comb begin
        for (int k = 0; k < N_M; k++) begin
            if (k < int'(pos))      order_d[k] = order_q[k];
            else if (k == N_M - 1)  order_d[k] = win_i;
            else                    order_d[k] = order_q[k+1];
        end
    end

    // List register; reset loads the fixed order.
    always_ff @(posedge clk) begin
        for (int k = 0; k < N_M; k++) begin
            if (!rst_n)     order_q[k] <= IW'(k);
            else if (upd_i) order_q[k] <= order_d[k];
        end
    end

    // Flatten the list for the selector.
    generate
        for (genvar g = 0; g < N_M; g++) begin : g_flat
            assign order_o[g*IW +: IW] = order_q[g];
        end
    endgenerate

    // Presence mask, used only to check that the list stays a permutation.
    always_comb begin
        seen = '0;
        for (int k = 0; k < N_M; k++) seen[order_q[k]] = 1'b1;
    end

    AST_LIST_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen) == N_M);                                         // R5
    AST_WINNER_AT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> order_q[N_M-1] == $past(win_i));                        // R5
    AST_LIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> order_q[0] == $past(order_q[0]));                      // R9
endmodule

// File: rtl/arb_pick.sv
// Combinational winner selection.
// In fixed mode the lowest index that requests wins. In rotating mode the
// earliest list entry that requests wins. any_o is 0 when nothing requests.
module arb_pick #(
    parameter int unsigned N_M   = pci_arb_pkg::NUM_M,
    localparam int unsigned IW   = $clog2(N_M)
) (
    input  logic [N_M-1:0]    req_i,
    input  logic              rr_i,
    input  logic [N_M*IW-1:0] order_i,
    output logic [IW-1:0]     win_o,
    output logic              any_o
);
    logic [IW-1:0] cand [N_M];

    // Choose the candidate sequence the active mode uses.
    generate
        for (genvar g = 0; g < N_M; g++) begin : g_cand
            assign cand[g] = rr_i ? order_i[g*IW +: IW] : IW'(g);
        end
    endgenerate

    // Scan from lowest to highest priority so the highest-priority requester is kept.
    always_comb begin
        win_o = '0;
        for (int k = N_M - 1; k >= 0; k--)
            if (req_i[cand[k]]) win_o = cand[k];
        any_o = |req_i;
    end
endmodule

// File: rtl/arb_grant_reg.sv
// Grant register with hand-over rule and host parking.
// The grant may move only when the bus is idle or the owner has dropped its
// request. With no requests, the grant returns to or stays on the host.
module arb_grant_reg #(
    parameter int unsigned N_M   = pci_arb_pkg::NUM_M,
    localparam int unsigned IW   = $clog2(N_M)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_M-1:0] req_i,
    input  logic           bus_idle_i,
    input  logic [IW-1:0]  win_i,
    input  logic           any_i,
    output logic [N_M-1:0] gnt_o,
    output logic           decide_o
);
    localparam logic [N_M-1:0] HOST_GNT = N_M'(1) << pci_arb_pkg::HOST;

    logic [N_M-1:0] gnt_q;
    logic           may_sw;

    // Switching is allowed when the bus is idle or the owner has released.
    always_comb begin
        may_sw   = bus_idle_i || !(|(req_i & gnt_q));
        decide_o = may_sw && any_i;
    end

    // Grant register: hand over to the winner, park on the host, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        gnt_q <= HOST_GNT;
        else if (decide_o) gnt_q <= N_M'(1) << win_i;
        else if (may_sw)   gnt_q <= HOST_GNT;
    end

    assign gnt_o = gnt_q;
endmodule

// File: rtl/pci_bus_arbiter.sv
// Top level of the two-mode bus arbiter (host bridge plus four devices).
// Connects the priority list, the winner selector and the grant register.
// The list rotates only on decisions taken in rotating mode.
module pci_bus_arbiter #(
    parameter int unsigned N_M   = pci_arb_pkg::NUM_M,
    localparam int unsigned IW   = $clog2(N_M)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N_M-1:0] req_i,
    input  logic           mode_rr_i,
    input  logic           bus_idle_i,
    output logic [N_M-1:0] gnt_o
);
    logic [N_M*IW-1:0] order;
    logic [IW-1:0]     win;
    logic              any_req;
    logic              decide;
    logic              may_move;

    arb_prio_list #(.N_M(N_M)) u_list (
        .clk(clk), .rst_n(rst_n), .upd_i(decide && mode_rr_i),
        .win_i(win), .order_o(order));

    arb_pick #(.N_M(N_M)) u_pick (
        .req_i(req_i), .rr_i(mode_rr_i), .order_i(order),
        .win_o(win), .any_o(any_req));

    arb_grant_reg #(.N_M(N_M)) u_gnt (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_idle_i(bus_idle_i),
        .win_i(win), .any_i(any_req), .gnt_o(gnt_o), .decide_o(decide));

    // Port-level view of the hand-over condition, used by the checks below.
    assign may_move = bus_idle_i || !(|(req_i & gnt_o));

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gnt_o) == 1);                                           // R1
    AST_OWNER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !may_move |=> $stable(gnt_o));                                     // R7
    AST_PARK_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (may_move && req_i == '0) |=> gnt_o == N_M'(1));                   // R8
    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (may_move && !mode_rr_i && req_i[0]) |=> gnt_o[0]);                // R4
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (may_move && !mode_rr_i && |req_i)
        |=> gnt_o == $past(req_i & (~req_i + N_M'(1))));                   // R3
endmodule

// File: tb/sim_pci_bus_arbiter.sv
`timescale 1ns/1ps
module sim_pci_bus_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic       mode = 1'b0;
    logic       idle = 1'b1;
    logic [4:0] gnt;

    int n_run = 0;
    int n_fail = 0;
    logic [4:0] m_gnt;
    int m_order [5];

    always #10 clk = ~clk;   // 50 MHz

    pci_bus_arbiter u0 (.clk(clk), .rst_n(rst_n), .req_i(req),
        .mode_rr_i(mode), .bus_idle_i(idle), .gnt_o(gnt));

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Winner the requirements call for, from the model list.
    function automatic int pick(input logic [4:0] r, input logic m);
        for (int k = 0; k < 5; k++) begin
            int c = m ? m_order[k] : k;
            if (r[c]) return c;
        end
        return 0;
    endfunction

    task automatic model_reset();
        m_gnt = 5'b00001;
        for (int k = 0; k < 5; k++) m_order[k] = k;
    endtask

    // Model update for one edge with the inputs currently applied.
    task automatic model_step();
        logic may = idle || !(|(req & m_gnt));
        if (may && |req) begin
            int w = pick(req, mode);
            m_gnt = 5'b1 << w;
            if (mode) begin
                int p = 0;
                for (int k = 0; k < 5; k++) if (m_order[k] == w) p = k;
                for (int k = p; k < 4; k++) m_order[k] = m_order[k+1];
                m_order[4] = w;
            end
        end else if (may) begin
            m_gnt = 5'b00001;
        end
    endtask

    task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Apply inputs at a falling edge, take one rising edge, compare at the next falling edge.
    task automatic cycle(input logic [4:0] r, input logic m, input logic i, input string tag);
        string t = tag;
        logic may;
        req = r; mode = m; idle = i;
        may = i || !(|(r & m_gnt));
        if (t == "") t = !may ? "R7" : (r == 0) ? "R8" : m ? "R5" : "R3";
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(t, gnt, m_gnt);
        check("R1", 5'(($countones(gnt) == 1) ? 1 : 0), 5'd1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        model_reset();
        check("R2", gnt, 5'b00001);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd1357));
        @(negedge clk);
        do_reset();
        check("R2", gnt, 5'b00001);

        // R6: the rotating list starts in fixed order.
        cycle(5'b11111, 1'b1, 1'b1, "R6"); check("R6", gnt, 5'b00001);
        cycle(5'b11111, 1'b1, 1'b1, "R6"); check("R6", gnt, 5'b00010);
        // R9: a fixed decision leaves the list alone; rotating picks up where it stopped.
        cycle(5'b11110, 1'b0, 1'b1, "R9"); check("R9", gnt, 5'b00010);
        cycle(5'b11111, 1'b1, 1'b1, "R9"); check("R9", gnt, 5'b00100);
        // R7: the owner keeps the grant while busy, even against the host.
        cycle(5'b00101, 1'b0, 1'b0, "R7"); check("R7", gnt, 5'b00100);
        // R4: the host wins once a change is allowed in fixed mode.
        cycle(5'b11111, 1'b0, 1'b1, "R4"); check("R4", gnt, 5'b00001);
        // R8: no requests means the bus parks on the host.
        cycle(5'b10000, 1'b0, 1'b1, "R3"); check("R3", gnt, 5'b10000);
        cycle(5'b00000, 1'b0, 1'b0, "R8"); check("R8", gnt, 5'b00001);

        // Random mix of requests, mode flips and busy phases.
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] r = 5'($urandom);
            logic m = ($urandom % 4) != 0;
            logic i = ($urandom % 3) == 0;
            if (n % 97 == 0) r = '0;
            cycle(r, m, i, "");
        end

        do_reset();
        cycle(5'b11110, 1'b1, 1'b1, "R6"); check("R6", gnt, 5'b00010);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule